// File: doc/BRIEF.md
# Partitioned Memory Write-Protect Controller

This block decides, for every byte write arriving from a serial-port front end, whether the write may reach a 272-byte memory map. The map has four regions. General-purpose memory sits at 000h–07Fh. A control and status register window sits at 080h–08Fh. The first lookup table sits at 090h–0CFh, and the second at 0D0h–10Fh. The decision is combinational. A grant or an abort is raised in the same cycle as the write strobe. When a granted write targets a storage region, a write enable is also raised and the address and data are passed to the storage array.

The block holds seven control bytes in the register window. Bits [1:0] of the first control byte form a lock code. Each step of the code adds one region to the protected set, in nested order: the general-purpose memory first, then the first table, then the second. An active-low write-protect pin overrides the lock code and blocks every write, including writes to the control bytes, so the lock cannot be lowered while the pin is held low. A combinational read port returns the control bytes, so software can see the lock state and the effect of reserved-bit clearing.

Top module: `memwp_ctrl`

## Requirements
- R1: After reset, control bytes 0–5 hold their power-on image (default all zero) and control byte 6 holds zero. All bytes read back as 00h at 080h–086h.
- R2: With lock code 00 and the pin high, writes to 000h–07Fh, 090h–0CFh and 0D0h–10Fh are granted. The write enable is asserted with the write address and data on the storage outputs.
- R3: With lock code 01, writes to 000h–07Fh are aborted. Writes to both tables are granted.
- R4: With lock code 10, writes to 000h–07Fh and 090h–0CFh are aborted. Writes to 0D0h–10Fh are granted.
- R5: With lock code 11, every write to 000h–07Fh and 090h–10Fh is aborted.
- R6: Grant and abort are asserted only in a cycle where the write strobe is high, and exactly one of them is asserted in such a cycle. An aborted write never raises the storage write enable.
- R7: While the write-protect pin is low, every write is aborted whatever the lock code. A write to the control bytes is also aborted in that state and leaves their content unchanged.
- R8: Writes to 080h–086h are granted whatever the lock code, as long as the pin is high. They do not raise the storage write enable. The new value is readable from the next cycle.
- R9: Writes to the status byte at 087h and to the reserved bytes at 088h–08Fh are aborted. These addresses read as 00h.
- R10: Writes to any address above 10Fh are aborted.
- R11: Reserved bits are cleared on write and read as 0. These are bit 2 of control byte 0, bits [7:4] of control byte 5, and bits [7:4] of control byte 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 9 | Write address |
| wr_data | input | 8 | Write data |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_addr | input | 9 | Register read address |
| rd_data | output | 8 | Register read data (00h outside 080h–086h) |
| wr_grant | output | 1 | Write accepted |
| wr_abort | output | 1 | Write rejected |
| mem_we | output | 1 | Storage array write enable |
| mem_addr | output | 9 | Storage array address |
| mem_data | output | 8 | Storage array data |

## Verification
The bench steps through every lock code and probes the region edges 07Fh/080h, 08Fh/090h, 0CFh/0D0h and 10Fh/110h. A design with an off-by-one boundary or nested regions in the wrong order would grant or abort the wrong byte at one of these edges. It holds the pin low and tries to rewrite the lock byte. A design that exempts the register window from the pin would let the lock be lowered. It writes all-ones to bytes with reserved bits and expects them back cleared. Random writes over the whole 9-bit space, with the pin mostly high, cross-check each decision against a bench model.

// File: rtl/memwp_ctrl.sv
module memwp_ctrl #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int N_CTL  = 7,
  parameter logic [ADDR_W-1:0] GPM_END   = 9'h07F,
  parameter logic [ADDR_W-1:0] REG_BASE  = 9'h080,
  parameter logic [ADDR_W-1:0] LUT1_BASE = 9'h090,
  parameter logic [ADDR_W-1:0] LUT2_BASE = 9'h0D0,
  parameter logic [ADDR_W-1:0] MAP_END   = 9'h10F,
  parameter logic [N_CTL*DATA_W-1:0] CTL_INIT  = '0,
  parameter logic [N_CTL*DATA_W-1:0] RSVD_MASK = 56'hF0_F0_00_00_00_00_04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_grant,
  output logic              wr_abort,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);

  localparam logic [ADDR_W-1:0] STAT_A = REG_BASE + ADDR_W'(N_CTL);

  logic [DATA_W-1:0] ctl_q [N_CTL];
  logic [1:0] lock_code;
  logic in_gpm, in_reg, in_lut1, in_lut2, locked, writable;

  assign lock_code = ctl_q[0][1:0];

  assign in_gpm  = wr_addr <= GPM_END;
  assign in_reg  = (wr_addr >= REG_BASE) && (wr_addr < STAT_A);
  assign in_lut1 = (wr_addr >= LUT1_BASE) && (wr_addr < LUT2_BASE);
  assign in_lut2 = (wr_addr >= LUT2_BASE) && (wr_addr <= MAP_END);

  assign locked = (in_gpm  && (lock_code != 2'b00)) ||
                  (in_lut1 && lock_code[1]) ||
                  (in_lut2 && (lock_code == 2'b11));

  assign writable = wp_n && (in_reg || ((in_gpm || in_lut1 || in_lut2) && !locked));

  assign wr_grant = wr_req && writable;
  assign wr_abort = wr_req && !writable;
  assign mem_we   = wr_grant && !in_reg;
  assign mem_addr = wr_addr;
  assign mem_data = wr_data;

  generate
    for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
      localparam logic [DATA_W-1:0] MASK = RSVD_MASK[i*DATA_W +: DATA_W];
      localparam logic [DATA_W-1:0] INIT =
        (i == N_CTL-1) ? '0 : (CTL_INIT[i*DATA_W +: DATA_W] & ~MASK);
      localparam logic [ADDR_W-1:0] MY_A = REG_BASE + ADDR_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctl_q[i] <= INIT;
        else if (wr_grant && wr_addr == MY_A)
          ctl_q[i] <= wr_data & ~MASK;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CTL; i++)
      if (rd_addr == REG_BASE + ADDR_W'(i)) rd_data = ctl_q[i];
  end

endmodule

// File: rtl/memwp_ctrl_chk.sv
module memwp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       wp_n,
  input logic [8:0] wr_addr,
  input logic       wr_grant,
  input logic       wr_abort,
  input logic       mem_we,
  input logic [1:0] lock_code
);

  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_grant != wr_abort));

  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (!wr_grant && !wr_abort && !mem_we));

  assert_pin_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wp_n) |-> wr_abort);

  assert_lock_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_addr == 9'h080) |=> $stable(lock_code));

  assert_beyond_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr > 9'h10F) |-> wr_abort);

  assert_gpm_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lock_code != 2'b00) |-> (wr_addr > 9'h07F));

  assert_lut1_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lock_code[1]) |-> (wr_addr >= 9'h0D0));

  assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (lock_code != 2'b11));

  assert_no_reg_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(wr_addr >= 9'h080 && wr_addr <= 9'h08F));

endmodule

bind memwp_ctrl memwp_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req    (wr_req),
  .wp_n      (wp_n),
  .wr_addr   (wr_addr),
  .wr_grant  (wr_grant),
  .wr_abort  (wr_abort),
  .mem_we    (mem_we),
  .lock_code (lock_code)
);

// File: tb/memwp_ctrl_tb.sv
module memwp_ctrl_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_req = 0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wp_n = 1;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_grant, wr_abort, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] exp_ctl [7];
  logic [7:0] msk [7];

  always #10 clk = ~clk;

  memwp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_n(wp_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_grant(wr_grant), .wr_abort(wr_abort), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h)", req, act, exp, wr_addr);
    end
  endtask

  function automatic bit exp_ok(logic [8:0] a, bit wp, logic [1:0] lk);
    if (!wp) return 0;
    if (a >= 9'h080 && a <= 9'h086) return 1;
    if (a > 9'h10F || (a >= 9'h087 && a <= 9'h08F)) return 0;
    if (a <= 9'h07F) return lk == 2'b00;
    if (a <= 9'h0CF) return lk < 2'b10;
    return lk != 2'b11;
  endfunction

  function automatic string tag_of(logic [8:0] a, bit wp, logic [1:0] lk);
    if (!wp) return "R7";
    if (a > 9'h10F) return "R10";
    if (a >= 9'h087 && a <= 9'h08F) return "R9";
    if (a >= 9'h080) begin
      if (a <= 9'h086) return "R8";
    end
    case (lk)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [8:0] a);
    if (a >= 9'h080 && a <= 9'h086) return exp_ctl[a - 9'h080];
    return 8'h00;
  endfunction

  task automatic do_wr(input logic [8:0] a, input logic [7:0] d, input bit wp, input logic [8:0] ra);
    bit ok, is_reg;
    string t;
    @(negedge clk);
    wr_addr = a; wr_data = d; wp_n = wp; wr_req = 1; rd_addr = ra;
    #2;
    ok = exp_ok(a, wp, exp_ctl[0][1:0]);
    is_reg = (a >= 9'h080 && a <= 9'h086);
    t = tag_of(a, wp, exp_ctl[0][1:0]);
    chk(wr_grant == ok, t, wr_grant, ok);
    chk(wr_abort == !ok, "R6", wr_abort, !ok);
    chk(mem_we == (ok && !is_reg), t, mem_we, ok && !is_reg);
    if (ok && !is_reg) chk(mem_addr == a && mem_data == d, "R2", {mem_addr, mem_data}, {a, d});
    chk(rd_data == exp_rd(ra), (ra >= 9'h087) ? "R9" : "R8", rd_data, exp_rd(ra));
    @(posedge clk);
    #1;
    if (ok && is_reg) exp_ctl[a - 9'h080] = d & ~msk[a - 9'h080];
    wr_req = 0;
  endtask

  task automatic rd_chk(input logic [8:0] ra, input string req);
    @(negedge clk);
    rd_addr = ra;
    #2;
    chk(rd_data == exp_rd(ra), req, rd_data, exp_rd(ra));
    chk(!wr_grant && !wr_abort && !mem_we, "R6", {wr_grant, wr_abort, mem_we}, 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] edges [10];
    void'($urandom(32'd4321));
    for (int i = 0; i < 7; i++) begin exp_ctl[i] = 8'h00; msk[i] = 8'h00; end
    msk[0] = 8'h04; msk[5] = 8'hF0; msk[6] = 8'hF0;
    edges = '{9'h000, 9'h07F, 9'h080, 9'h087, 9'h08F, 9'h090, 9'h0CF, 9'h0D0, 9'h10F, 9'h110};

    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int a = 9'h080; a <= 9'h08F; a++) rd_chk(9'(a), (a <= 9'h086) ? "R1" : "R9");

    for (int lk = 0; lk < 4; lk++) begin
      do_wr(9'h080, 8'(lk), 1'b1, 9'h080);
      rd_chk(9'h080, "R8");
      foreach (edges[k]) do_wr(edges[k] == 9'h080 ? 9'h081 : edges[k], 8'h5A, 1'b1, 9'h081);
      do_wr(9'h1FF, 8'hA5, 1'b1, 9'h086);
    end

    for (int a = 9'h087; a <= 9'h08F; a++) do_wr(9'(a), 8'hFF, 1'b1, 9'(a));
    for (int a = 9'h087; a <= 9'h08F; a++) rd_chk(9'(a), "R9");

    do_wr(9'h080, 8'h03, 1'b1, 9'h080);
    do_wr(9'h080, 8'h00, 1'b0, 9'h080);
    rd_chk(9'h080, "R7");
    do_wr(9'h084, 8'h77, 1'b0, 9'h084);
    rd_chk(9'h084, "R7");
    do_wr(9'h010, 8'h11, 1'b0, 9'h080);

    do_wr(9'h080, 8'hFF, 1'b1, 9'h080);
    rd_chk(9'h080, "R11");
    do_wr(9'h085, 8'hFF, 1'b1, 9'h085);
    rd_chk(9'h085, "R11");
    do_wr(9'h086, 8'hFF, 1'b1, 9'h086);
    rd_chk(9'h086, "R11");
    do_wr(9'h083, 8'hFF, 1'b1, 9'h083);
    rd_chk(9'h083, "R8");

    for (int n = 0; n < 1500; n++) begin
      logic [8:0] a;
      logic [8:0] ra;
      int sel;
      sel = $urandom_range(9, 0);
      if (sel < 2)      a = 9'h080;
      else if (sel < 4) a = 9'($urandom_range(9'h08F, 9'h078));
      else              a = 9'($urandom_range(511, 0));
      ra = 9'($urandom_range(9'h093, 9'h07C));
      do_wr(a, 8'($urandom_range(255, 0)), $urandom_range(7, 0) != 0, ra);
      if ($urandom_range(3, 0) == 0) rd_chk(ra, "R8");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule